// File: doc/BRIEF.md
# Shifted-Operand Subtract Unit with Condition Flags

This execute-stage unit computes `opa - shift(opb)` on 32-bit register values for a register-to-register subtract instruction. The second operand goes through a barrel shifter first. Four shift kinds are supported, with an amount from 0 to 31. The subtraction is then formed as `opa + ~shifted + 1`. Carry therefore means "no borrow", and signed overflow comes out of the same addition.

The result is steered to one of two places: the register-file write port, or a separate program-counter write port when the destination index is 15. A write to the program counter never changes the flags. The N/Z/C/V flags update only when the instruction's condition passed and its set-flags bit is on. In every other case the flag outputs carry the incoming flag values with the flag enable low. A condition that fails cancels the instruction completely.

The outputs are held in one register stage with a valid/ready handshake. An operation is taken in when `in_valid && in_ready`. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle (`out_ready`). While `out_valid` is high and `out_ready` is low, the slot holds its contents and no new operation is taken in. The enables (`rf_we`, `pc_we`, `flags_we`) are meaningful only while `out_valid` is high. They are low whenever the slot is empty.

Top module: `subsh_unit`

## Requirements
- R1: The result is `opa - S(opb)`, where S is selected by `shift_kind`: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. The shift distance is `shift_amt` (0..31), and an amount of 0 passes `opb` unchanged.
- R2: When flags update, N (flags bit 3) equals result bit 31, and Z (flags bit 2) is 1 exactly when the 32-bit result is zero.
- R3: When flags update, C (flags bit 1) is the carry-out of `opa + ~S(opb) + 1`, so it is 1 when no borrow occurs.
- R4: When flags update, V (flags bit 0) is 1 when both addends of that sum share a sign and the result's sign differs from it.
- R5: With `set_flags` low, `flags_we` is 0 and `flags_out` equals the `flags_in` of that operation, while the register write still happens.
- R6: With `dest_idx` = 15 and the condition passed, `pc_we` is 1, `pc_wdata` carries the result, and both `rf_we` and `flags_we` are 0, even when `set_flags` is high.
- R7: With `cond_ok` low, `rf_we`, `pc_we` and `flags_we` are all 0, and `flags_out` equals `flags_in`.
- R8: Outputs appear one clock after acceptance. Synchronous reset clears `out_valid`, every enable and `flags_out`. With no new input and `out_ready` high, the slot empties and the enables drop.
- R9: `in_ready` = `!out_valid || out_ready`. While `out_valid && !out_ready`, every output holds its value and a new input is not taken in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Unit can accept an operation |
| opa | input | 32 | First operand (minuend) |
| opb | input | 32 | Operand to be shifted and subtracted |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt | input | 5 | Shift distance |
| flags_in | input | 4 | Current {N,Z,C,V} |
| cond_ok | input | 1 | Condition evaluated true |
| set_flags | input | 1 | Instruction requests a flag update |
| dest_idx | input | 4 | Destination register index |
| out_valid | output | 1 | Output slot holds a result |
| out_ready | input | 1 | Consumer takes the output slot |
| rf_wdata | output | 32 | Register write data |
| rf_waddr | output | 4 | Register write index |
| rf_we | output | 1 | Register write enable |
| pc_wdata | output | 32 | Program-counter write data |
| pc_we | output | 1 | Program-counter write enable |
| flags_out | output | 4 | Next {N,Z,C,V} |
| flags_we | output | 1 | Flag update enable |

## Verification
The arithmetic is driven through a table of operand pairs chosen to isolate each flag:
- an equal pair separates Z from the other flags;
- a small-minus-large pair shows C at 0 (borrow) with N set;
- a pair that crosses the most-negative and most-positive boundaries shows V independent of C;
- an all-ones pair gives zero with carry.

Each shift kind is applied with a nonzero amount on operands where a wrong kind gives a different result. Arithmetic right is given a negative value so that it cannot be confused with logical right, and rotate right is given a set low bit so that it cannot be confused with a plain shift. Directed cases then vary only one control at a time: set-flags, destination 15 and condition-failed. These show that gating acts on the enables and not on the data. A stalled consumer shows that the slot holds and that the next operation is taken in only after it drains.

// File: rtl/subsh_pkg.sv
package subsh_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/subsh_shifter.sv
module subsh_shifter #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  import subsh_pkg::*;

  logic [2*W-1:0] rot_wide;

  always_comb begin
    rot_wide = {din, din} >> amt;
    unique case (shift_kind_e'(kind))
      SH_LSL:  dout = din << amt;
      SH_LSR:  dout = din >> amt;
      SH_ASR:  dout = W'($signed(din) >>> amt);
      default: dout = rot_wide[W-1:0];
    endcase
  end
endmodule

// File: rtl/subsh_adder.sv
module subsh_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] diff,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] inv_b;
  logic [W:0]   wide_sum;

  always_comb begin
    inv_b    = ~subtrahend;
    wide_sum = {1'b0, minuend} + {1'b0, inv_b} + (W+1)'(1);
    diff     = wide_sum[W-1:0];
    carry    = wide_sum[W];
    ovf      = (minuend[W-1] == inv_b[W-1]) && (diff[W-1] != minuend[W-1]);
  end
endmodule

// File: rtl/subsh_commit.sv
module subsh_commit #(
  parameter int W      = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic              cond_ok,
  input  logic              set_flags,
  input  logic [IDX_W-1:0]  dest_idx,
  input  logic [W-1:0]      diff,
  input  logic              carry,
  input  logic              ovf,
  input  subsh_pkg::nzcv_t  flags_cur,
  output logic              rf_we,
  output logic              pc_we,
  output logic              flags_we,
  output subsh_pkg::nzcv_t  flags_nxt
);
  logic to_pc;

  always_comb begin
    to_pc    = (dest_idx == IDX_W'(PC_IDX));
    rf_we    = cond_ok && !to_pc;
    pc_we    = cond_ok && to_pc;
    flags_we = cond_ok && set_flags && !to_pc;
    if (flags_we) begin
      flags_nxt.n = diff[W-1];
      flags_nxt.z = (diff == '0);
      flags_nxt.c = carry;
      flags_nxt.v = ovf;
    end else begin
      flags_nxt = flags_cur;
    end
  end
endmodule

// File: rtl/subsh_unit.sv
module subsh_unit #(
  parameter int W      = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15,
  localparam int AW    = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [1:0]       shift_kind,
  input  logic [AW-1:0]    shift_amt,
  input  logic [3:0]       flags_in,
  input  logic             cond_ok,
  input  logic             set_flags,
  input  logic [IDX_W-1:0] dest_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     rf_wdata,
  output logic [IDX_W-1:0] rf_waddr,
  output logic             rf_we,
  output logic [W-1:0]     pc_wdata,
  output logic             pc_we,
  output logic [3:0]       flags_out,
  output logic             flags_we
);
  import subsh_pkg::*;

  logic [W-1:0] shifted, diff;
  logic         carry, ovf;
  logic         c_rf_we, c_pc_we, c_flags_we;
  nzcv_t        c_flags;
  logic         accept;

  logic [W-1:0]     res_q;
  logic [IDX_W-1:0] idx_q;
  logic             rf_we_q, pc_we_q, flags_we_q, valid_q;
  nzcv_t            flags_q;

  subsh_shifter #(.W(W)) u_shift (
    .din(opb), .kind(shift_kind), .amt(shift_amt), .dout(shifted)
  );

  subsh_adder #(.W(W)) u_add (
    .minuend(opa), .subtrahend(shifted), .diff(diff), .carry(carry), .ovf(ovf)
  );

  subsh_commit #(.W(W), .IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_commit (
    .cond_ok(cond_ok), .set_flags(set_flags), .dest_idx(dest_idx),
    .diff(diff), .carry(carry), .ovf(ovf), .flags_cur(nzcv_t'(flags_in)),
    .rf_we(c_rf_we), .pc_we(c_pc_we), .flags_we(c_flags_we), .flags_nxt(c_flags)
  );

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= 1'b0;
      rf_we_q    <= 1'b0;
      pc_we_q    <= 1'b0;
      flags_we_q <= 1'b0;
      flags_q    <= '0;
      res_q      <= '0;
      idx_q      <= '0;
    end else if (accept) begin
      valid_q    <= 1'b1;
      rf_we_q    <= c_rf_we;
      pc_we_q    <= c_pc_we;
      flags_we_q <= c_flags_we;
      flags_q    <= c_flags;
      res_q      <= diff;
      idx_q      <= dest_idx;
    end else if (out_ready) begin
      valid_q    <= 1'b0;
      rf_we_q    <= 1'b0;
      pc_we_q    <= 1'b0;
      flags_we_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign rf_wdata  = res_q;
  assign pc_wdata  = res_q;
  assign rf_waddr  = idx_q;
  assign rf_we     = rf_we_q;
  assign pc_we     = pc_we_q;
  assign flags_we  = flags_we_q;
  assign flags_out = flags_q;

  // R6: program-counter path excludes register and flag writes
  p_pc_excl_r6: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> (!rf_we && !flags_we));

  // R8: enables only accompany a filled slot
  p_en_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (rf_we || pc_we || flags_we) |-> out_valid);

  // R9: a stalled slot keeps its contents
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(rf_wdata) && $stable(flags_out)
                                   && $stable(rf_we) && $stable(pc_we)));

  // R2: stored Z matches stored result
  p_zflag_r2: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_out[2] == (rf_wdata == '0)));

  // R2: stored N matches stored result sign
  p_nflag_r2: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_out[3] == rf_wdata[W-1]));

  // R7: accepted failed-condition operation yields no enables
  p_cond_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && !cond_ok) |=> (!rf_we && !pc_we && !flags_we));

endmodule

// File: tb/subsh_unit_tb_top.sv
module subsh_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [31:0] opa, opb;
  logic [1:0]  shift_kind;
  logic [4:0]  shift_amt;
  logic [3:0]  flags_in;
  logic        cond_ok, set_flags;
  logic [3:0]  dest_idx;
  logic        out_valid, out_ready;
  logic [31:0] rf_wdata, pc_wdata;
  logic [3:0]  rf_waddr, flags_out;
  logic        rf_we, pc_we, flags_we;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  subsh_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .flags_in(flags_in), .cond_ok(cond_ok), .set_flags(set_flags),
    .dest_idx(dest_idx), .out_valid(out_valid), .out_ready(out_ready),
    .rf_wdata(rf_wdata), .rf_waddr(rf_waddr), .rf_we(rf_we),
    .pc_wdata(pc_wdata), .pc_we(pc_we), .flags_out(flags_out), .flags_we(flags_we)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [1:0]  k;
    logic [4:0]  amt;
    logic [31:0] exp_res;
    logic [3:0]  exp_f;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0005, 32'h0000_0003, 2'd0, 5'd0,  32'h0000_0002, 4'b0010},
    '{32'h0000_0003, 32'h0000_0005, 2'd0, 5'd0,  32'hFFFF_FFFE, 4'b1000},
    '{32'h8000_0000, 32'h0000_0001, 2'd0, 5'd0,  32'h7FFF_FFFF, 4'b0011},
    '{32'h0000_0007, 32'h0000_0007, 2'd1, 5'd0,  32'h0000_0000, 4'b0110},
    '{32'h0000_0100, 32'h0000_0001, 2'd0, 5'd4,  32'h0000_00F0, 4'b0010},
    '{32'h0000_0100, 32'h0000_0080, 2'd1, 5'd3,  32'h0000_00F0, 4'b0010},
    '{32'h0000_0000, 32'h8000_0000, 2'd2, 5'd4,  32'h0800_0000, 4'b0000},
    '{32'h0000_0010, 32'h0000_0001, 2'd3, 5'd4,  32'hF000_0010, 4'b1000},
    '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd0, 5'd0,  32'h8000_0000, 4'b1001},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 5'd0,  32'h0000_0000, 4'b0110}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] k,
                       input logic [4:0] amt, input logic [3:0] f, input logic c,
                       input logic s, input logic [3:0] d);
    @(negedge clk);
    in_valid = 1'b1; opa = a; opb = b; shift_kind = k; shift_amt = amt;
    flags_in = f; cond_ok = c; set_flags = s; dest_idx = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    opa = '0; opb = '0; shift_kind = '0; shift_amt = '0; flags_in = '0;
    cond_ok = 1'b0; set_flags = 1'b0; dest_idx = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset out_valid", 32'(out_valid), 0);
    chk("R8 reset enables", {29'd0, rf_we, pc_we, flags_we}, 0);
    chk("R8 reset flags", 32'(flags_out), 0);
    chk("R9 ready when empty", 32'(in_ready), 1);
    rst = 1'b0;

    // R1 R2 R3 R4: table of arithmetic vectors
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].a, VEC[i].b, VEC[i].k, VEC[i].amt, 4'b0000, 1'b1, 1'b1, 4'd2);
      chk($sformatf("R1 result v%0d", i), rf_wdata, VEC[i].exp_res);
      chk($sformatf("R2 NZ v%0d", i), 32'(flags_out[3:2]), 32'(VEC[i].exp_f[3:2]));
      chk($sformatf("R3 C v%0d", i), 32'(flags_out[1]), 32'(VEC[i].exp_f[1]));
      chk($sformatf("R4 V v%0d", i), 32'(flags_out[0]), 32'(VEC[i].exp_f[0]));
      chk($sformatf("R1 enables v%0d", i), {29'd0, rf_we, pc_we, flags_we}, 32'b101);
      chk($sformatf("R1 waddr v%0d", i), 32'(rf_waddr), 2);
    end

    // R8: slot empties with no new input
    @(negedge clk);
    chk("R8 drain valid", 32'(out_valid), 0);
    chk("R8 drain enables", {29'd0, rf_we, pc_we, flags_we}, 0);

    // R5: no set-flags keeps incoming flags
    drive(32'd9, 32'd4, 2'd0, 5'd0, 4'b1010, 1'b1, 1'b0, 4'd3);
    chk("R5 flags_we", 32'(flags_we), 0);
    chk("R5 flags pass", 32'(flags_out), 32'b1010);
    chk("R5 reg write", {31'd0, rf_we}, 1);
    chk("R5 data", rf_wdata, 32'd5);

    // R6: destination 15 takes the PC path, no flags
    drive(32'h0000_1000, 32'h0000_0004, 2'd0, 5'd0, 4'b0101, 1'b1, 1'b1, 4'd15);
    chk("R6 pc_we", 32'(pc_we), 1);
    chk("R6 rf_we", 32'(rf_we), 0);
    chk("R6 flags_we", 32'(flags_we), 0);
    chk("R6 pc data", pc_wdata, 32'h0000_0FFC);
    chk("R6 flags pass", 32'(flags_out), 32'b0101);

    // R7: failed condition cancels everything
    drive(32'd5, 32'd5, 2'd0, 5'd0, 4'b1001, 1'b0, 1'b1, 4'd1);
    chk("R7 enables", {29'd0, rf_we, pc_we, flags_we}, 0);
    chk("R7 flags pass", 32'(flags_out), 32'b1001);
    drive(32'd5, 32'd5, 2'd0, 5'd0, 4'b1001, 1'b0, 1'b1, 4'd15);
    chk("R7 pc cancelled", 32'(pc_we), 0);

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; opa = 32'd100; opb = 32'd1; shift_kind = 2'd0; shift_amt = 5'd0;
    flags_in = 4'b0000; cond_ok = 1'b1; set_flags = 1'b1; dest_idx = 4'd4;
    @(negedge clk);
    chk("R9 captured", rf_wdata, 32'd99);
    chk("R9 ready low", 32'(in_ready), 0);
    opa = 32'd50; opb = 32'd50;
    @(negedge clk);
    chk("R9 hold data", rf_wdata, 32'd99);
    chk("R9 hold valid", 32'(out_valid), 1);
    chk("R9 hold flags", 32'(flags_out), 32'b0010);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next taken", rf_wdata, 32'd0);
    chk("R9 next flags", 32'(flags_out), 32'b0110);

    // R8: reset clears a filled slot
    drive(32'd1, 32'd2, 2'd0, 5'd0, 4'b0000, 1'b1, 1'b1, 4'd6);
    chk("R8 filled", 32'(flags_out), 32'b1000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 reset flags", 32'(flags_out), 0);
    chk("R8 reset valid", 32'(out_valid), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule